// File: doc/BRIEF.md
# VCO Band Autoselect Controller

This block chooses one of 24 oscillator sub-bands for a synthesizer. A 3-bit quantized reading of the loop tuning voltage is fed back to it. When automatic selection is enabled and the divider's fractional low byte is loaded, the block starts at a programmed band. After each band change it waits a fixed settling time, then reads the tuning code. It moves the band up or down until the code sits in the inner window, which leaves headroom for temperature drift.

The block reports whether a search is still running and whether the last search succeeded. One readback byte carries the chosen band with the most recently captured code. With automatic selection off, the band comes straight from the programmed value. The code is then captured only by an explicit latch request, and only while the read path is enabled.

Top module: `vco_band_seek`

## Requirements
- R1: Out of reset, `seek_idle` is 1, `seek_ok` is 0, the internal band is 0 and the code field of `readback` is 000.
- R2: When `divlsb_wr` is high at a clock edge with `auto_en` high, a search starts at that edge. From the next cycle `seek_idle` is 0 and `band` equals the clamped `start_band`.
- R3: After each band change, `band` is held for SETTLE_CYCLES clock edges. The tuning code is evaluated at the SETTLE_CYCLES-th edge after the change.
- R4: Tuning codes 000, 001 and 011 step the band up by one. Codes 100, 110 and 111 step it down by one.
- R5: Codes 010 and 101 form the window. An evaluation that sees either one ends the search with `seek_idle`=1 and `seek_ok`=1, and `band` keeps the accepted value.
- R6: A step that would go above band 23 or below band 0 ends the search with `seek_idle`=1 and `seek_ok`=0. `band` keeps its last value.
- R7: The search ends as a failure (`seek_idle`=1, `seek_ok`=0) if the 24th evaluation does not see a window code.
- R8: A new `divlsb_wr` during a search restarts it at the clamped `start_band` with a fresh evaluation count.
- R9: With `auto_en` low, `band` equals the clamped `start_band`, `divlsb_wr` has no effect and `seek_idle` is 1 from the next cycle.
- R10: With `auto_en` low, `code_latch_wr` captures `tune_code` into the readback code field only when `code_rd_en` is high. Otherwise the field is unchanged.
- R11: `readback` carries `band` in bits 7:3 and the last captured code in bits 2:0. In automatic mode a code is captured at every evaluation.
- R12: A `start_band` above 23 is treated as 23.
- R13: `seek_ok` is 0 whenever `auto_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_en | input | 1 | 1 selects automatic band search, 0 selects manual band |
| start_band | input | 5 | Manual band, and the starting band of a search |
| divlsb_wr | input | 1 | Pulse when the fractional-divider low byte is written |
| code_rd_en | input | 1 | Manual mode: enables the tuning-code read path |
| code_latch_wr | input | 1 | Manual mode: request to capture the tuning code |
| tune_code | input | 3 | Quantized tuning-voltage code |
| band | output | 5 | Selected sub-band |
| seek_idle | output | 1 | 1 when no search is running |
| seek_ok | output | 1 | 1 after a search that ended in the window |
| readback | output | 8 | {band, captured code} |

## Verification
The hardest case to reach is the search that never converges. Neither end of the band range is hit, and the loop still stops only because the evaluation count runs out. The bench drives the tuning code from the design's own band through a small model of the loop. One profile flips the code between just below and just above a chosen band, so the search bounces between two bands until all 24 evaluations are used. The other profiles cover convergence from below and from above, pinning against each end, and a restart in the middle of a search.

// File: rtl/vco_band_seek.sv
module vco_band_seek #(
  parameter int NUM_BANDS     = 24,
  parameter int BAND_W        = 5,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              auto_en,
  input  logic [BAND_W-1:0] start_band,
  input  logic              divlsb_wr,
  input  logic              code_rd_en,
  input  logic              code_latch_wr,
  input  logic [2:0]        tune_code,
  output logic [BAND_W-1:0] band,
  output logic              seek_idle,
  output logic              seek_ok,
  output logic [BAND_W+2:0] readback
);

  localparam int CNT_W  = $clog2(SETTLE_CYCLES + 1);
  localparam int EVAL_W = $clog2(NUM_BANDS + 1);
  localparam logic [BAND_W-1:0] TOP      = BAND_W'(NUM_BANDS - 1);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [EVAL_W-1:0] EV_LAST  = EVAL_W'(NUM_BANDS - 1);

  logic              busy_q, ok_q;
  logic [BAND_W-1:0] band_q;
  logic [2:0]        code_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [EVAL_W-1:0] evals_q;

  logic [BAND_W-1:0] start_c;
  logic win, up, sample, give_up;

  assign start_c = (start_band > TOP) ? TOP : start_band;
  assign win     = (tune_code == 3'b010) || (tune_code == 3'b101);
  assign up      = ~tune_code[2];
  assign sample  = busy_q && (cnt_q == CNT_LAST);
  assign give_up = (evals_q == EV_LAST) || (up && band_q == TOP) ||
                   (!up && band_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ok_q    <= 1'b0;
      band_q  <= '0;
      code_q  <= '0;
      cnt_q   <= '0;
      evals_q <= '0;
    end else if (!auto_en) begin
      busy_q <= 1'b0;
      ok_q   <= 1'b0;
      band_q <= start_c;
      if (code_latch_wr && code_rd_en) code_q <= tune_code;
    end else if (divlsb_wr) begin
      busy_q  <= 1'b1;
      ok_q    <= 1'b0;
      band_q  <= start_c;
      cnt_q   <= '0;
      evals_q <= '0;
    end else if (sample) begin
      code_q <= tune_code;
      cnt_q  <= '0;
      if (win) begin
        busy_q <= 1'b0;
        ok_q   <= 1'b1;
      end else if (give_up) begin
        busy_q <= 1'b0;
        ok_q   <= 1'b0;
      end else begin
        band_q  <= up ? band_q + BAND_W'(1) : band_q - BAND_W'(1);
        evals_q <= evals_q + EVAL_W'(1);
      end
    end else if (busy_q) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign band      = auto_en ? band_q : start_c;
  assign seek_idle = ~busy_q;
  assign seek_ok   = ok_q & auto_en;
  assign readback  = {band, code_q};

  assert_band_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    band <= TOP);

  assert_trig_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (divlsb_wr && auto_en) |=> !seek_idle);

  assert_settle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |-> $stable(band_q));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(divlsb_wr)) |->
      (band_q == $past(band_q) || band_q == $past(band_q) + BAND_W'(1) ||
       band_q + BAND_W'(1) == $past(band_q)));

  assert_ok_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seek_ok |-> seek_idle);

  assert_manual_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> seek_idle);

endmodule

// File: tb/vco_band_seek_tb.sv
`timescale 1ns/1ps
module vco_band_seek_tb;
  localparam int S = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic auto_en = 1'b1, divlsb_wr = 1'b0, code_rd_en = 1'b0, code_latch_wr = 1'b0;
  logic [4:0] start_band = 5'd0;
  logic [2:0] tune_code;
  logic [4:0] band;
  logic seek_idle, seek_ok;
  logic [7:0] readback;

  int p_mode = 0, p_target = 0, p_alt = 0;
  int checks = 0, errors = 0, cycles = 0;

  always #2 clk = ~clk;

  vco_band_seek #(.NUM_BANDS(24), .BAND_W(5), .SETTLE_CYCLES(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .start_band(start_band),
    .divlsb_wr(divlsb_wr), .code_rd_en(code_rd_en), .code_latch_wr(code_latch_wr),
    .tune_code(tune_code), .band(band), .seek_idle(seek_idle), .seek_ok(seek_ok),
    .readback(readback));

  function automatic logic [2:0] plant(input int b);
    case (p_mode)
      0: if (b < p_target - 2) return 3'b000;
         else if (b < p_target) return 3'b001;
         else if (b == p_target) return p_alt ? 3'b101 : 3'b010;
         else if (b <= p_target + 2) return 3'b110;
         else return 3'b111;
      1: return 3'b000;
      2: return 3'b111;
      3: return (b < p_target) ? 3'b001 : 3'b110;
      default: return 3'(p_target);
    endcase
  endfunction

  assign tune_code = plant(int'(band));

  function automatic int clampb(input int v);
    return (v > 23) ? 23 : v;
  endfunction

  int m_busy, m_ok, m_band, m_code, m_cnt, m_ev;

  always @(posedge clk) begin
    int t;
    t = int'(tune_code);
    if (!rst_n) begin
      m_busy = 0; m_ok = 0; m_band = 0; m_code = 0; m_cnt = 0; m_ev = 0;
    end else if (!auto_en) begin
      m_busy = 0; m_ok = 0; m_band = clampb(int'(start_band));
      if (code_latch_wr && code_rd_en) m_code = t;
    end else if (divlsb_wr) begin
      m_busy = 1; m_ok = 0; m_band = clampb(int'(start_band)); m_cnt = 0; m_ev = 0;
    end else if (m_busy != 0) begin
      if (m_cnt == S - 1) begin
        m_code = t; m_cnt = 0;
        if (t == 2 || t == 5) begin m_busy = 0; m_ok = 1; end
        else if (m_ev == 23 || (t < 4 && m_band == 23) || (t >= 4 && m_band == 0)) begin
          m_busy = 0; m_ok = 0;
        end else begin
          m_band = (t < 4) ? m_band + 1 : m_band - 1;
          m_ev++;
        end
      end else m_cnt++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int eb;
      eb = auto_en ? m_band : clampb(int'(start_band));
      check("R4 band", int'(band), eb);
      check("R5 seek_idle", int'(seek_idle), (m_busy == 0) ? 1 : 0);
      check("R13 seek_ok", int'(seek_ok), (auto_en && m_ok != 0) ? 1 : 0);
      check("R11 readback", int'(readback), eb * 8 + m_code);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic trigger();
    divlsb_wr = 1'b1; tick(); divlsb_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      if (seek_idle) break;
      tick();
    end
  endtask

  initial begin
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    check("R1 idle", int'(seek_idle), 1);
    check("R1 ok", int'(seek_ok), 0);
    check("R1 band", int'(band), 0);
    check("R1 code", int'(readback[2:0]), 0);
    rst_n = 1'b1; tick();

    // upward search, window code 010
    p_mode = 0; p_target = 15; p_alt = 0; start_band = 5'd10;
    trigger();
    check("R2 busy", int'(seek_idle), 0);
    check("R2 start band", int'(band), 10);
    for (int i = 0; i < S - 1; i++) tick();
    check("R3 band held", int'(band), 10);
    tick();
    check("R3 R4 step up", int'(band), 11);
    wait_idle();
    check("R5 band", int'(band), 15);
    check("R5 ok", int'(seek_ok), 1);
    check("R11 readback", int'(readback), 15 * 8 + 2);

    // downward search, window code 101
    p_target = 5; p_alt = 1; start_band = 5'd20;
    trigger(); wait_idle();
    check("R4 R5 down band", int'(band), 5);
    check("R5 ok alt", int'(seek_ok), 1);
    check("R11 readback alt", int'(readback), 5 * 8 + 5);

    // pinned at top
    p_mode = 1; start_band = 5'd23;
    trigger(); wait_idle();
    check("R6 top band", int'(band), 23);
    check("R6 top ok", int'(seek_ok), 0);

    // pinned at bottom
    p_mode = 2; start_band = 5'd0;
    trigger(); wait_idle();
    check("R6 bottom band", int'(band), 0);
    check("R6 bottom ok", int'(seek_ok), 0);

    // oscillation exhausts evaluations
    p_mode = 3; p_target = 10; start_band = 5'd10;
    trigger();
    for (int i = 0; i < 24 * S - 1; i++) tick();
    check("R7 still busy", int'(seek_idle), 0);
    tick();
    check("R7 idle", int'(seek_idle), 1);
    check("R7 ok", int'(seek_ok), 0);
    check("R7 readback", int'(readback), 9 * 8 + 1);

    // clamp of start band
    p_mode = 0; p_target = 20; p_alt = 0; start_band = 5'd30;
    trigger();
    check("R12 clamp", int'(band), 23);
    wait_idle();
    check("R12 result", int'(band), 20);

    // restart during search
    p_target = 12; start_band = 5'd5;
    trigger();
    for (int i = 0; i < 3 * S; i++) tick();
    start_band = 5'd8;
    trigger();
    check("R8 restart band", int'(band), 8);
    check("R8 busy", int'(seek_idle), 0);
    for (int i = 0; i < S; i++) tick();
    check("R8 first step", int'(band), 9);
    wait_idle();
    check("R8 result", int'(band), 12);

    // disabling auto clears ok
    auto_en = 1'b0; tick();
    check("R13 ok cleared", int'(seek_ok), 0);

    // manual mode
    start_band = 5'd7; tick();
    check("R9 manual band", int'(band), 7);
    trigger(); tick();
    check("R9 trigger ignored", int'(seek_idle), 1);
    start_band = 5'd30; tick();
    check("R9 R12 manual clamp", int'(band), 23);

    p_mode = 5; p_target = 6; code_rd_en = 1'b1;
    code_latch_wr = 1'b1; tick(); code_latch_wr = 1'b0; tick();
    check("R10 latched", int'(readback[2:0]), 6);
    p_target = 3; code_rd_en = 1'b0;
    code_latch_wr = 1'b1; tick(); code_latch_wr = 1'b0; tick();
    check("R10 latch without read path", int'(readback[2:0]), 6);
    code_rd_en = 1'b1; tick();
    check("R10 no latch request", int'(readback[2:0]), 6);
    tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule